// File: doc/BRIEF.md
# Serial Byte FIFO Pair with Packed Fill Reporting

This block sits between a serial controller's shifters and its register interface. It holds two byte-wide queues: receive bytes arrive from the deserialiser and leave through the register interface, and transmit bytes arrive from the register interface and leave toward the serialiser. Each queue is 16 entries deep by default. One 32-bit status word reports the receive fill, the transmit fill and the transmit free space, so software can poll a single location before it moves data.

Each direction has its own 32-bit control word with three fields: an enable bit, a flush bit that clears itself, and a trigger level. The receive side raises a one-cycle request when its fill climbs to the trigger level. The transmit side raises a one-cycle request each time its fill drops to a value at or below the trigger level. Software can shut a direction down with a single control write that clears the enable bit and sets the flush bit together.

Top module: `serial_fifo_pair`

## Requirements
- R1: `fifo_status` carries the receive fill in bits [5:0], the transmit fill in bits [13:8] and the transmit free count in bits [29:24]. All other bits read 0.
- R2: In a control word, bit 0 is enable, bit 1 is flush and bits [13:8] are the trigger level. Reading the word back returns the last written enable and trigger values with all other bits 0. Both control words are 0 after reset.
- R3: Each queue holds DEPTH bytes (16 by default) and returns them in the order they were pushed. A push raises the fill by one and a pop lowers it by one. A push and a pop in the same cycle on a queue that is neither empty nor full leave the fill unchanged.
- R4: `tx_empty` is 1 exactly when the transmit fill is zero.
- R5: A push into a full queue is dropped: the fill and the stored bytes stay the same. A pop from an empty queue is ignored.
- R6: A control write with bit 1 set empties that direction at the write edge and leaves the other direction unchanged. The flush bit reads back as 1 for one cycle after the write and then as 0.
- R7: While a direction's enable bit is 0, its pushes are ignored and its fill reads 0. Clearing enable discards any stored bytes.
- R8: `rx_req` is high for one cycle: the first cycle in which the receive fill shows a value that is higher than the previous cycle's and equal to the receive trigger level, with receive enabled.
- R9: `tx_req` is high in each cycle in which the transmit fill shows a value that is lower than the previous cycle's and at or below the transmit trigger level, with transmit enabled. A drop caused by a flush counts.
- R10: The transmit free count always equals DEPTH minus the transmit fill. After reset it is DEPTH.
- R11: A single transmit control write of value 0x2 (enable 0, flush 1) empties the transmit queue, leaves it disabled, and causes later pushes to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ctl_wr | input | 1 | Write strobe for the receive control word |
| rx_ctl_wdata | input | 32 | Receive control write data |
| tx_ctl_wr | input | 1 | Write strobe for the transmit control word |
| tx_ctl_wdata | input | 32 | Transmit control write data |
| rx_ctl_rdata | output | 32 | Receive control word readback |
| tx_ctl_rdata | output | 32 | Transmit control word readback |
| fifo_status | output | 32 | Packed fill and free-space status |
| rx_push | input | 1 | Push a byte from the deserialiser |
| rx_push_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop the receive head byte |
| rx_head | output | 8 | Oldest receive byte, valid when the receive fill is non-zero |
| tx_push | input | 1 | Push a byte from the register interface |
| tx_push_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop the transmit head byte to the serialiser |
| tx_head | output | 8 | Oldest transmit byte, valid when the transmit fill is non-zero |
| tx_empty | output | 1 | Transmit queue empty |
| rx_req | output | 1 | Receive trigger-level request pulse |
| tx_req | output | 1 | Transmit trigger-level request pulse |

## Verification
The bench builds the block with its defaults: DEPTH 16 and 8-bit data. At these values every fill level from 0 to 16, plus one overfill push, is driven for every trigger value from 0 to 17, including the two trigger values that can never be reached. The request pulses, the free count and the empty flag are therefore compared against arithmetic expectations at every level in both directions. Flush isolation between the two directions, simultaneous push and pop, disabled pushes and the one-write shutdown are exercised as separate scenarios.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  localparam int LVL_W       = 6;
  localparam int EN_BIT      = 0;
  localparam int FLUSH_BIT   = 1;
  localparam int TRIG_LSB    = 8;
  localparam int RX_FILL_LSB = 0;
  localparam int TX_FILL_LSB = 8;
  localparam int TX_FREE_LSB = 24;

  typedef struct packed {
    logic [LVL_W-1:0] trig;
    logic             flush;
    logic             en;
  } ctl_t;

  function automatic logic [31:0] ctl_word(input ctl_t c);
    logic [31:0] w;
    w = '0;
    w[EN_BIT]                     = c.en;
    w[FLUSH_BIT]                  = c.flush;
    w[TRIG_LSB +: LVL_W]          = c.trig;
    return w;
  endfunction

  function automatic logic [31:0] pack_status(input logic [LVL_W-1:0] rx_fill,
                                              input logic [LVL_W-1:0] tx_fill,
                                              input logic [LVL_W-1:0] tx_free);
    logic [31:0] w;
    w = '0;
    w[RX_FILL_LSB +: LVL_W] = rx_fill;
    w[TX_FILL_LSB +: LVL_W] = tx_fill;
    w[TX_FREE_LSB +: LVL_W] = tx_free;
    return w;
  endfunction

  function automatic logic [LVL_W-1:0] free_count(input int depth,
                                                  input logic [LVL_W-1:0] fill);
    return LVL_W'(depth) - fill;
  endfunction

endpackage

// File: rtl/sfp_ctl_reg.sv
module sfp_ctl_reg
  import sfp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        en,
  output logic [LVL_W-1:0] trig,
  output logic        flush_now
);

  ctl_t ctl_q;
  wire  unused_wdata = ^{wdata[31:TRIG_LSB+LVL_W], wdata[TRIG_LSB-1:2]};

  // flush strike is taken at the write edge itself
  assign flush_now = wr && wdata[FLUSH_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q.flush <= flush_now;
      if (wr) begin
        ctl_q.en   <= wdata[EN_BIT];
        ctl_q.trig <= wdata[TRIG_LSB +: LVL_W];
      end
    end
  end

  assign en    = ctl_q.en;
  assign trig  = ctl_q.trig;
  assign rdata = ctl_word(ctl_q);

  p_flush_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> rdata[FLUSH_BIT]);

  p_flush_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[FLUSH_BIT] && !wr) |=> !rdata[FLUSH_BIT]);

  p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(en) && $stable(trig)));

endmodule

// File: rtl/sfp_byte_fifo.sv
module sfp_byte_fifo
  import sfp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              flush_now,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;

  // named internal events for the assertions
  wire hold_clear = !en || flush_now;
  wire is_full    = (cnt == FULL_CNT);
  wire is_empty   = (cnt == '0);
  wire do_push    = !hold_clear && push && !is_full;
  wire do_pop     = !hold_clear && pop && !is_empty;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (hold_clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  assign head  = mem[rd_ptr];
  assign level = en ? LVL_W'(cnt) : '0;

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flush_now && is_full && push && !pop) |=> (cnt == FULL_CNT));

  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flush_now && is_empty && pop && !push) |=> (cnt == '0));

  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (cnt == '0));

  p_disabled_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

endmodule

// File: rtl/sfp_req_gen.sv
module sfp_req_gen
  import sfp_pkg::*;
#(
  parameter bit RISING = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  output logic             req
);

  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level;
  end

  wire went_up   = level > level_q;
  wire went_down = level < level_q;

  generate
    if (RISING) begin : g_rise
      assign req = en && went_up && (level == trig);

      p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (!req || (trig != $past(trig))));
    end else begin : g_fall
      assign req = en && went_down && (level <= trig);

      p_fall_needs_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(level) && en) |-> !req);
    end
  endgenerate

endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import sfp_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_ctl_wr,
  input  logic [31:0]       rx_ctl_wdata,
  input  logic              tx_ctl_wr,
  input  logic [31:0]       tx_ctl_wdata,
  output logic [31:0]       rx_ctl_rdata,
  output logic [31:0]       tx_ctl_rdata,
  output logic [31:0]       fifo_status,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_push_data,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_head,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_push_data,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_head,
  output logic              tx_empty,
  output logic              rx_req,
  output logic              tx_req
);

  logic             rx_en, tx_en, rx_flush, tx_flush;
  logic [LVL_W-1:0] rx_trig, tx_trig, rx_level, tx_level, tx_free;

  sfp_ctl_reg u_rx_ctl (
    .clk(clk), .rst_n(rst_n), .wr(rx_ctl_wr), .wdata(rx_ctl_wdata),
    .rdata(rx_ctl_rdata), .en(rx_en), .trig(rx_trig), .flush_now(rx_flush)
  );

  sfp_ctl_reg u_tx_ctl (
    .clk(clk), .rst_n(rst_n), .wr(tx_ctl_wr), .wdata(tx_ctl_wdata),
    .rdata(tx_ctl_rdata), .en(tx_en), .trig(tx_trig), .flush_now(tx_flush)
  );

  sfp_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .flush_now(rx_flush),
    .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
    .head(rx_head), .level(rx_level)
  );

  sfp_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .flush_now(tx_flush),
    .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
    .head(tx_head), .level(tx_level)
  );

  sfp_req_gen #(.RISING(1'b1)) u_rx_req (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .level(rx_level),
    .trig(rx_trig), .req(rx_req)
  );

  sfp_req_gen #(.RISING(1'b0)) u_tx_req (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .level(tx_level),
    .trig(tx_trig), .req(tx_req)
  );

  assign tx_free     = free_count(DEPTH, tx_level);
  assign fifo_status = pack_status(rx_level, tx_level, tx_free);
  assign tx_empty    = (tx_level == '0);

  p_free_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_status[TX_FREE_LSB +: LVL_W]) + 32'(fifo_status[TX_FILL_LSB +: LVL_W]))
      == 32'(DEPTH));

  p_tx_req_below_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (fifo_status[TX_FILL_LSB +: LVL_W] <= tx_ctl_rdata[TRIG_LSB +: LVL_W]));

  p_rx_req_at_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |-> (fifo_status[RX_FILL_LSB +: LVL_W] == rx_ctl_rdata[TRIG_LSB +: LVL_W]));

  p_empty_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (fifo_status[TX_FREE_LSB +: LVL_W] == LVL_W'(DEPTH)));

  p_disabled_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ctl_rdata[EN_BIT] |-> (fifo_status[RX_FILL_LSB +: LVL_W] == '0));

endmodule

// File: tb/tb_serial_fifo_pair.sv
`timescale 1ns/1ps
module tb_serial_fifo_pair;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_ctl_wr, tx_ctl_wr;
  logic [31:0] rx_ctl_wdata, tx_ctl_wdata;
  logic [31:0] rx_ctl_rdata, tx_ctl_rdata, fifo_status;
  logic        rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0]  rx_push_data, tx_push_data, rx_head, tx_head;
  logic        tx_empty, rx_req, tx_req;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  serial_fifo_pair #(.DEPTH(DEPTH), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n),
    .rx_ctl_wr(rx_ctl_wr), .rx_ctl_wdata(rx_ctl_wdata),
    .tx_ctl_wr(tx_ctl_wr), .tx_ctl_wdata(tx_ctl_wdata),
    .rx_ctl_rdata(rx_ctl_rdata), .tx_ctl_rdata(tx_ctl_rdata),
    .fifo_status(fifo_status),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_head(rx_head),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_head(tx_head),
    .tx_empty(tx_empty), .rx_req(rx_req), .tx_req(tx_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock edge; inputs driven at negedge, results sampled at the next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    rx_ctl_wr = 0; tx_ctl_wr = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
  endtask

  function automatic logic [31:0] ctlv(input int trig, input bit fl, input bit en);
    return (32'(trig) << 8) | (32'(fl) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] stat(input int rxf, input int txf);
    return 32'(rxf) | (32'(txf) << 8) | (32'(DEPTH - txf) << 24);
  endfunction

  function automatic logic [7:0] pat(input int a, input int b);
    return 8'(a * 19 + b * 7 + 3);
  endfunction

  task automatic wr_rx(input logic [31:0] v);
    rx_ctl_wr = 1; rx_ctl_wdata = v; step(); rx_ctl_wr = 0;
  endtask

  task automatic wr_tx(input logic [31:0] v);
    tx_ctl_wr = 1; tx_ctl_wdata = v; step(); tx_ctl_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; rx_ctl_wdata = 0; tx_ctl_wdata = 0; rx_push_data = 0; tx_push_data = 0;
    idle_inputs();
    repeat (3) step();
    rst_n = 1;
    step();

    // reset state: R1, R2, R4, R10
    chk("R1 reset status", fifo_status, stat(0, 0));
    chk("R2 reset rx ctl", rx_ctl_rdata, 0);
    chk("R2 reset tx ctl", tx_ctl_rdata, 0);
    chk("R4 reset empty", 32'(tx_empty), 1);
    chk("R10 reset free", 32'(fifo_status[29:24]), DEPTH);

    // R7: disabled pushes ignored
    rx_push = 1; rx_push_data = 8'h5A; tx_push = 1; tx_push_data = 8'hA5;
    step(); idle_inputs();
    chk("R7 disabled push", fifo_status, stat(0, 0));

    // receive sweep over every trigger level: R2, R3, R5, R6, R8
    for (int t = 0; t <= DEPTH + 1; t++) begin
      wr_rx(ctlv(t, 1, 1));
      chk("R2 rx ctl readback", rx_ctl_rdata, ctlv(t, 1, 1));
      chk("R6 rx flushed", 32'(fifo_status[5:0]), 0);
      for (int k = 1; k <= DEPTH + 1; k++) begin
        rx_push = 1; rx_push_data = pat(t, k);
        step(); rx_push = 0;
        chk("R3 R5 rx level", 32'(fifo_status[5:0]), (k <= DEPTH) ? k : DEPTH);
        chk("R8 rx req", 32'(rx_req), (k <= DEPTH && k == t) ? 1 : 0);
        if (k == 1) chk("R6 flush self clear", rx_ctl_rdata, ctlv(t, 0, 1));
      end
      for (int k = 1; k <= DEPTH; k++) begin
        chk("R3 R5 rx order", 32'(rx_head), 32'(pat(t, k)));
        rx_pop = 1; step(); rx_pop = 0;
        chk("R8 rx req on pop", 32'(rx_req), 0);
      end
      rx_pop = 1; step(); rx_pop = 0;
      chk("R5 rx pop empty", 32'(fifo_status[5:0]), 0);
    end

    // transmit sweep over every trigger level: R3, R4, R5, R9, R10
    for (int t = 0; t <= DEPTH + 1; t++) begin
      wr_tx(ctlv(t, 1, 1));
      chk("R9 no req on empty flush", 32'(tx_req), 0);
      for (int k = 1; k <= DEPTH + 1; k++) begin
        tx_push = 1; tx_push_data = pat(t + 40, k);
        step(); tx_push = 0;
        chk("R5 tx level", 32'(fifo_status[13:8]), (k <= DEPTH) ? k : DEPTH);
        chk("R9 tx req on fill", 32'(tx_req), 0);
      end
      chk("R10 free at full", 32'(fifo_status[29:24]), 0);
      for (int k = 1; k <= DEPTH; k++) begin
        chk("R3 tx order", 32'(tx_head), 32'(pat(t + 40, k)));
        tx_pop = 1; step(); tx_pop = 0;
        chk("R3 tx level", 32'(fifo_status[13:8]), DEPTH - k);
        chk("R9 tx req", 32'(tx_req), (DEPTH - k <= t) ? 1 : 0);
        chk("R4 tx empty", 32'(tx_empty), (k == DEPTH) ? 1 : 0);
        chk("R10 tx free", 32'(fifo_status[29:24]), k);
      end
    end

    // R1 packing and R6 isolation
    wr_rx(ctlv(0, 1, 1)); wr_tx(ctlv(0, 1, 1));
    for (int k = 0; k < 5; k++) begin
      rx_push = 1; rx_push_data = 8'(k + 1); tx_push = (k < 3); tx_push_data = 8'(k + 100);
      step(); idle_inputs();
    end
    chk("R1 packed status", fifo_status, stat(5, 3));
    wr_rx(ctlv(0, 1, 1));
    chk("R6 rx flush isolated", fifo_status, stat(0, 3));
    chk("R6 tx head kept", 32'(tx_head), 100);

    // R3 simultaneous push and pop
    rx_push = 1; rx_push_data = 8'h11; step();
    rx_push_data = 8'h22; step(); idle_inputs();
    rx_push = 1; rx_pop = 1; rx_push_data = 8'h33; step(); idle_inputs();
    chk("R3 push pop level", 32'(fifo_status[5:0]), 2);
    chk("R3 push pop head", 32'(rx_head), 8'h22);

    // R11 shutdown write on transmit
    wr_tx(32'h2);
    chk("R11 shutdown readback", tx_ctl_rdata, 32'h2);
    chk("R11 shutdown empty", 32'(fifo_status[13:8]), 0);
    chk("R11 no req when off", 32'(tx_req), 0);
    tx_push = 1; tx_push_data = 8'h77; step(); idle_inputs();
    chk("R11 push after shutdown", fifo_status, stat(2, 0));
    chk("R4 empty after shutdown", 32'(tx_empty), 1);

    // R7 clearing enable discards receive bytes
    wr_rx(ctlv(0, 0, 0));
    wr_rx(ctlv(0, 0, 1));
    chk("R7 discard on disable", 32'(fifo_status[5:0]), 0);

    finish_run();
  end

endmodule